// File: doc/BRIEF.md
# Slow-Clock Counter with Domain-Crossing Register Access

This block is an up-counter that runs on its own slow oscillator clock. The processor never touches the counter's clock domain directly. The processor stages compare and control writes in holding registers and sends them across to the timer domain with a toggle handshake. A busy output for each register stays high until the new value has been captured on a timer edge and the acknowledgement has come back.

The count and two event flags travel the other way. The overflow flag and the compare flag each move as a toggle through a two-flop synchroniser, and the processor-side copy of the count is refreshed each time the count toggle arrives. The compare output pin is driven straight from the timer domain.

A sleep input freezes every processor-side register. After wake-up the count view keeps the pre-sleep value until a fresh timer edge has crossed. Software gets a reliable count by writing a register, waiting for its busy flag to drop, and then reading.

Top module: `async_timer`

## Requirements
- R1: While control bit 0 (run) is set in the timer domain, the count rises by one on every timer-clock rising edge, modulo 2^CNT_W. While run is clear, the count holds.
- R2: The overflow flag sets when the count wraps from its maximum to 0. Writing flag_clr_i[0]=1 clears it.
- R3: The compare flag sets on the timer edge where the count becomes equal to the compare register. Writing flag_clr_i[1]=1 clears it.
- R4: When control bit 1 (toggle) is set, the compare pin inverts on each compare match. It changes only on timer-clock edges, and it holds when bit 1 is clear.
- R5: An accepted write raises its busy output on the next processor edge. The new value takes effect on the third timer edge after the write. Busy clears on the third processor edge after that timer edge.
- R6: A write to a register whose busy output is high is discarded, and the value already in flight is kept.
- R7: cnt_o takes the new count on the third processor-clock rising edge after each timer edge.
- R8: Each event flag is set on the third processor-clock rising edge after the timer edge that raised the event.
- R9: While sleep_i is high, the count view and the flags hold. After wake-up, the count view keeps its pre-sleep value through the first three awake cycles and until a later timer edge crosses. Once a busy flag clears after a write made after wake-up, cnt_o equals the live count.
- R10: After reset the count view, both flags, both busy outputs and the pin are 0, and the compare value, control value and count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| tclk_i | input | 1 | Slow timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| sleep_i | input | 1 | Gates all processor-side registers while high |
| wdata_i | input | CNT_W | Write data for compare (all bits) or control (bits 1:0) |
| cmp_wr_i | input | 1 | Write strobe, compare register |
| ctl_wr_i | input | 1 | Write strobe, control register |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 compare |
| cnt_o | output | CNT_W | Processor-side view of the count |
| cmp_busy_o | output | 1 | Compare transfer pending |
| ctl_busy_o | output | 1 | Control transfer pending |
| ovf_flag_o | output | 1 | Overflow event flag |
| cmp_flag_o | output | 1 | Compare match event flag |
| cmp_pin_o | output | 1 | Compare output pin, timer domain |

## Verification
The bench builds the block with CNT_W = 8. This makes a full wrap reachable in 256 timer edges, so the overflow flag and a second pass through the compare value both fit in a short run. The timer clock is 16 processor periods long with a 1 ns phase offset. That keeps the three-cycle crossing latency well inside one timer period, which lets the reference model predict busy, count view and flags on an exact processor cycle. The sleep cases wake just after a timer edge, so the stale window before the next edge is long enough to observe.

// File: rtl/atmr_pkg.sv
package atmr_pkg;
  localparam int unsigned CTL_W      = 2;
  localparam int unsigned WAKE_FLUSH = 3;

  typedef struct packed {
    logic tgl_en;
    logic run;
  } tctl_t;
endpackage

// File: rtl/atmr_sync.sv
module atmr_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (en_i) begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/atmr_xfer.sv
module atmr_xfer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         tclk_i,
  input  logic         rst_ni,
  input  logic         awake_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic [W-1:0] tval_o
);
  logic [W-1:0] hold_q, tval_q;
  logic         req_q, req_s, req_seen_q, ack_s, ack_seen_q;
  logic         accept, load;

  assign accept = awake_i & wr_i & ~busy_o;

  // processor side staging
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      req_q  <= 1'b0;
    end else if (accept) begin
      hold_q <= wdata_i;
      req_q  <= ~req_q;
    end
  end

  atmr_sync #(.W(1)) i_req_sync (
    .clk_i(tclk_i), .rst_ni(rst_ni), .en_i(1'b1), .d_i(req_q), .q_o(req_s)
  );

  assign load = req_s ^ req_seen_q;

  // timer side capture; req_seen_q doubles as the ack toggle
  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_seen_q <= 1'b0;
      tval_q     <= '0;
    end else if (load) begin
      req_seen_q <= req_s;
      tval_q     <= hold_q;
    end
  end

  atmr_sync #(.W(1)) i_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(awake_i), .d_i(req_seen_q), .q_o(ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ack_seen_q <= 1'b0;
    else if (awake_i) ack_seen_q <= ack_s;
  end

  assign busy_o = req_q ^ ack_seen_q;
  assign tval_o = tval_q;

  a_r5_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
  a_r6_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_o) |=> ($stable(hold_q) && $stable(req_q)));
  a_r5_load_value: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    load |=> (tval_q == $past(hold_q)));
endmodule

// File: rtl/atmr_core.sv
module atmr_core
  import atmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             tclk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cmp_i,
  input  tctl_t            ctl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [2:0]       tog_o,
  output logic             pin_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             cnt_tog_q, ovf_tog_q, cmp_tog_q, pin_q;

  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      cnt_tog_q <= 1'b0;
      ovf_tog_q <= 1'b0;
      cmp_tog_q <= 1'b0;
      pin_q     <= 1'b0;
    end else begin
      cnt_tog_q <= ~cnt_tog_q; // every edge refreshes the processor view
      if (ctl_i.run) begin
        cnt_q <= cnt_nx;
        if (cnt_q == CNT_MAX) ovf_tog_q <= ~ovf_tog_q;
        if (cnt_nx == cmp_i) begin
          cmp_tog_q <= ~cmp_tog_q;
          if (ctl_i.tgl_en) pin_q <= ~pin_q;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign tog_o = {cmp_tog_q, ovf_tog_q, cnt_tog_q};
  assign pin_o = pin_q;

  a_r1_step: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    ctl_i.run |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r1_hold: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    !ctl_i.run |=> $stable(cnt_q));
  a_r2_wrap_event: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    (ctl_i.run && cnt_q == CNT_MAX) |=> (ovf_tog_q != $past(ovf_tog_q)));
  a_r4_pin_quiet: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    !ctl_i.tgl_en |=> $stable(pin_q));
endmodule

// File: rtl/atmr_view.sv
module atmr_view
  import atmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic [CNT_W-1:0] tcnt_i,
  input  logic [2:0]       tog_i,
  input  logic [1:0]       clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             cmpf_o
);
  localparam int unsigned FL_W = $clog2(WAKE_FLUSH + 1);

  logic             awake;
  logic [2:0]       tog_s, tog_seen_q, edge_v;
  logic [FL_W-1:0]  flush_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, cmpf_q;

  assign awake = ~sleep_i;

  atmr_sync #(.W(3)) i_tog_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(awake), .d_i(tog_i), .q_o(tog_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tog_seen_q <= '0;
    else if (awake) tog_seen_q <= tog_s;
  end

  assign edge_v = tog_s ^ tog_seen_q;

  // wake flush: runs ungated, absorbs stale count toggles held over sleep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flush_q <= '0;
    else if (sleep_i)         flush_q <= FL_W'(WAKE_FLUSH);
    else if (flush_q != '0)   flush_q <= flush_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else if (awake) begin
      if (flush_q == '0 && edge_v[0]) cnt_q <= tcnt_i;
      ovf_q  <= edge_v[1] | (ovf_q  & ~clr_i[0]);
      cmpf_q <= edge_v[2] | (cmpf_q & ~clr_i[1]);
    end
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign cmpf_o = cmpf_q;

  a_r9_sleep_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(cnt_q) && $stable(ovf_q) && $stable(cmpf_q)));
  a_r9_flush_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q != '0) |=> $stable(cnt_q));
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && clr_i[0] && !edge_v[1]) |=> !ovf_q);
  a_r8_cmp_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && edge_v[2]) |=> cmpf_q);
endmodule

// File: rtl/async_timer.sv
module async_timer
  import atmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             tclk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cmp_wr_i,
  input  logic             ctl_wr_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmp_busy_o,
  output logic             ctl_busy_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o,
  output logic             cmp_pin_o
);
  logic             awake;
  logic [CNT_W-1:0] cmp_t, tcnt;
  logic [CTL_W-1:0] ctl_raw;
  tctl_t            ctl_t;
  logic [2:0]       tog;

  assign awake = ~sleep_i;
  assign ctl_t = tctl_t'(ctl_raw);

  atmr_xfer #(.W(CNT_W)) i_cmp_xfer (
    .clk_i(clk_i), .tclk_i(tclk_i), .rst_ni(rst_ni), .awake_i(awake),
    .wr_i(cmp_wr_i), .wdata_i(wdata_i), .busy_o(cmp_busy_o), .tval_o(cmp_t)
  );

  atmr_xfer #(.W(CTL_W)) i_ctl_xfer (
    .clk_i(clk_i), .tclk_i(tclk_i), .rst_ni(rst_ni), .awake_i(awake),
    .wr_i(ctl_wr_i), .wdata_i(wdata_i[CTL_W-1:0]), .busy_o(ctl_busy_o),
    .tval_o(ctl_raw)
  );

  atmr_core #(.CNT_W(CNT_W)) i_core (
    .tclk_i(tclk_i), .rst_ni(rst_ni), .cmp_i(cmp_t), .ctl_i(ctl_t),
    .cnt_o(tcnt), .tog_o(tog), .pin_o(cmp_pin_o)
  );

  atmr_view #(.CNT_W(CNT_W)) i_view (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .tcnt_i(tcnt),
    .tog_i(tog), .clr_i(flag_clr_i), .cnt_o(cnt_o), .ovf_o(ovf_flag_o),
    .cmpf_o(cmp_flag_o)
  );
endmodule

// File: tb/test_async_timer.sv
module test_async_timer;
  localparam int CW   = 8;
  localparam int MAXC = 255;

  logic          clk = 1'b0, tclk = 1'b0, rst_ni = 1'b0, sleep_i = 1'b0;
  logic          cmp_wr_i = 1'b0, ctl_wr_i = 1'b0;
  logic [CW-1:0] wdata_i = '0;
  logic [1:0]    flag_clr_i = '0;
  logic [CW-1:0] cnt_o;
  logic          cmp_busy_o, ctl_busy_o, ovf_flag_o, cmp_flag_o, cmp_pin_o;

  async_timer #(.CNT_W(CW)) i_async_timer (
    .clk_i(clk), .tclk_i(tclk), .rst_ni(rst_ni), .sleep_i(sleep_i),
    .wdata_i(wdata_i), .cmp_wr_i(cmp_wr_i), .ctl_wr_i(ctl_wr_i),
    .flag_clr_i(flag_clr_i), .cnt_o(cnt_o), .cmp_busy_o(cmp_busy_o),
    .ctl_busy_o(ctl_busy_o), .ovf_flag_o(ovf_flag_o),
    .cmp_flag_o(cmp_flag_o), .cmp_pin_o(cmp_pin_o)
  );

  always #2 clk = ~clk; // 250 MHz
  initial begin #1; forever #32 tclk = ~tclk; end

  int m_cnt = 0, m_cmp = 0, pend_cmp = 0, pend_ctl = 0, v_cmp = 0, v_ctl = 0;
  int m_view = 0;
  bit m_run = 0, m_tgl = 0, m_pin = 0, m_bc = 0, m_bt = 0, m_ovf = 0, m_cmpf = 0;
  bit chk_en = 0, done = 0;
  int n_chk = 0, n_fail = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // timer-domain reference step, processor-side effects three clk edges later
  task automatic tick();
    int nxt;
    bit eo, ek, ac, at;
    nxt = m_cnt; eo = 0; ek = 0; ac = 0; at = 0;
    if (m_run) begin
      nxt = (m_cnt + 1) % (MAXC + 1);
      eo  = (m_cnt == MAXC);
      if (nxt == m_cmp) begin
        ek = 1;
        if (m_tgl) m_pin = ~m_pin;
      end
    end
    m_cnt = nxt;
    if (pend_cmp > 0) begin
      pend_cmp--;
      if (pend_cmp == 0) begin m_cmp = v_cmp; ac = 1; end
    end
    if (pend_ctl > 0) begin
      pend_ctl--;
      if (pend_ctl == 0) begin m_run = v_ctl[0]; m_tgl = v_ctl[1]; at = 1; end
    end
    fork
      begin
        repeat (3) @(posedge clk);
        m_view = nxt;
        if (eo) m_ovf = 1;
        if (ek) m_cmpf = 1;
        if (ac) m_bc = 0;
        if (at) m_bt = 0;
      end
    join_none
  endtask

  always @(posedge tclk) if (rst_ni) tick();
  always @(negedge tclk) if (rst_ni && !done) check("R4 pin", int'(cmp_pin_o), int'(m_pin));

  always @(negedge clk) begin
    if (chk_en && !done) begin
      check("R7 count view", int'(cnt_o), m_view);
      check("R5 cmp busy", int'(cmp_busy_o), int'(m_bc));
      check("R5 ctl busy", int'(ctl_busy_o), int'(m_bt));
      check("R2 ovf flag", int'(ovf_flag_o), int'(m_ovf));
      check("R8 cmp flag", int'(cmp_flag_o), int'(m_cmpf));
    end
  end

  task automatic wr_reg(bit is_ctl, int val);
    @(negedge clk);
    wdata_i = val[CW-1:0];
    if (is_ctl) ctl_wr_i = 1'b1; else cmp_wr_i = 1'b1;
    @(posedge clk);
    if (is_ctl) begin
      if (!m_bt) begin m_bt = 1; pend_ctl = 3; v_ctl = val; end
    end else begin
      if (!m_bc) begin m_bc = 1; pend_cmp = 3; v_cmp = val; end
    end
    @(negedge clk);
    ctl_wr_i = 1'b0; cmp_wr_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_bc || m_bt);
  endtask

  task automatic clr_flags(logic [1:0] mask);
    @(negedge clk);
    flag_clr_i = mask;
    @(posedge clk);
    if (mask[0]) m_ovf = 0;
    if (mask[1]) m_cmpf = 0;
    @(negedge clk);
    flag_clr_i = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v, p, x;
    #10;
    // R10 reset state
    check("R10 reset view", int'(cnt_o), 0);
    check("R10 reset busy", int'(cmp_busy_o | ctl_busy_o), 0);
    check("R10 reset flags", int'(ovf_flag_o | cmp_flag_o), 0);
    check("R10 reset pin", int'(cmp_pin_o), 0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    chk_en = 1;

    // R5 busy, R6 ignored second write
    wr_reg(0, 5);
    check("R5 busy after write", int'(cmp_busy_o), 1);
    wr_reg(0, 9);
    wait_idle();
    check("R5 busy cleared", int'(cmp_busy_o), 0);
    wr_reg(1, 3);
    wait_idle();

    // R3/R4/R6: match happens at 5, not 9
    while (m_view != 7) @(negedge clk);
    check("R6 kept first compare value", int'(cmp_flag_o), 1);
    check("R3 cmp flag set", int'(cmp_flag_o), 1);
    check("R4 pin toggled on match", int'(cmp_pin_o), 1);
    clr_flags(2'b10);
    check("R3 cmp flag cleared", int'(cmp_flag_o), 0);

    // R7 latency: tclk edge, then negedges after p1, p2, p3
    @(posedge tclk);
    @(negedge clk);
    x = m_cnt;
    check("R7 not yet after 1st clk edge", int'(cnt_o), (x + MAXC) % (MAXC + 1));
    @(negedge clk);
    check("R7 not yet after 2nd clk edge", int'(cnt_o), (x + MAXC) % (MAXC + 1));
    @(negedge clk);
    check("R7 updated after 3rd clk edge", int'(cnt_o), x);
    check("R1 step of one", x, (int'(cnt_o)));

    // R2 overflow
    while (m_cnt != MAXC) @(negedge tclk);
    check("R2 no flag before wrap", int'(ovf_flag_o), 0);
    @(posedge tclk);
    repeat (4) @(negedge clk);
    check("R2 ovf flag after wrap", int'(ovf_flag_o), 1);
    check("R1 wrapped to zero", int'(cnt_o), 0);
    clr_flags(2'b01);
    check("R2 ovf flag cleared", int'(ovf_flag_o), 0);

    // R4 toggle disabled: pin holds through a match
    wr_reg(1, 1);
    wait_idle();
    clr_flags(2'b10);
    p = int'(cmp_pin_o);
    while (m_view != 4) @(negedge clk);
    while (m_view != 7) @(negedge clk);
    check("R3 match seen again", int'(cmp_flag_o), 1);
    check("R4 pin held with toggle off", int'(cmp_pin_o), p);

    // R9 stale view across sleep
    @(posedge tclk);
    repeat (4) @(negedge clk);
    v = int'(cnt_o);
    check("R9 view live before sleep", v, m_cnt);
    chk_en = 0;
    sleep_i = 1'b1;
    repeat (5) @(posedge tclk);
    @(negedge clk);
    check("R9 view frozen in sleep", int'(cnt_o), v);
    @(posedge tclk);
    @(negedge clk);
    sleep_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R9 stale after wake", int'(cnt_o), v);
    end
    @(posedge tclk);
    @(negedge clk);
    x = m_cnt;
    check("R9 stale until edge crosses", int'(cnt_o), v);
    @(negedge clk);
    check("R9 stale until edge crosses", int'(cnt_o), v);
    @(negedge clk);
    check("R9 fresh after next edge", int'(cnt_o), x);
    m_view = x;
    repeat (4) @(negedge clk);
    clr_flags(2'b11);
    m_ovf = 0; m_cmpf = 0;
    chk_en = 1;

    // R9 safe read procedure after an unaligned wake
    chk_en = 0;
    @(negedge clk);
    sleep_i = 1'b1;
    repeat (203) @(negedge clk);
    sleep_i = 1'b0;
    wr_reg(0, 5);
    wait_idle();
    check("R9 safe read after busy clears", int'(cnt_o), m_cnt);
    m_view = m_cnt;
    repeat (4) @(negedge clk);
    clr_flags(2'b11);
    m_ovf = 0; m_cmpf = 0;
    m_view = int'(cnt_o) == m_cnt ? m_cnt : m_view;
    chk_en = 1;

    // R1 hold when run clear
    wr_reg(1, 0);
    wait_idle();
    v = int'(cnt_o);
    repeat (5) @(posedge tclk);
    repeat (4) @(negedge clk);
    check("R1 count holds when stopped", int'(cnt_o), v);

    done = 1;
    summary();
    $finish;
  end
endmodule